// File: doc/BRIEF.md
# I2C SCL Period and Quarter-Strobe Generator

This block sets the bit timing of an I2C master. A clock-control word carries two fields: a prescale count, which slows the peripheral clock down to an internal tick, and a period step count, which sets how many ticks one SCL cycle lasts. A separate small input adds a compensation term for the bus rise time, fall time and internal delay, already converted to ticks. From these values the block produces two outputs that request SCL low or SCL high. It also produces a one-clock strobe with a two-bit index at each quarter of the period. A byte engine uses these strobes to place START, STOP and data transitions.

A run input turns the timebase on. While run is low, every counter is held cleared and SCL is requested high. While run is high, a new control word is taken in only where one period ends and the next begins, so a period in progress is never reshaped. A variant parameter picks a 2-bit or a 3-bit prescale field, and that choice moves the position of the period field inside the control word.

Top module: `scl_timebase`

## Requirements
- R1: The internal tick occurs once every CDF+1 peripheral clocks, where CDF is the prescale field. The period position advances by one on each tick. With run held high from its rising edge, the position in clock k is floor(k/(CDF+1)) mod P.
- R2: The control word holds CDF in its low PW bits and the 6-bit period step field S in the bits directly above them. PW is 2 when WIDE_PSC=0 and 3 when WIDE_PSC=1, so CDF spans 0..3 or 0..7.
- R3: One SCL period lasts P = 20 + 8·S + C ticks, where S is the period step field (0..63) and C is the 5-bit compensation input.
- R4: SCL low is requested for the first L = ceil(P/2) ticks of each period. SCL high is requested for the remaining floor(P/2) ticks. Exactly one of the two requests is active in every clock.
- R5: A strobe lasting one clock marks the first clock of position 0 (index 0), of position floor(L/2) (index 1), of position L (index 2), and of position L + floor(floor(P/2)/2) (index 3). No strobe occurs in any other clock.
- R6: While run is low, the block requests SCL high and gives no strobe in that same clock. The counters clear, so the next rising edge of run starts at position 0 and gives an index-0 strobe in its first clock.
- R7: A control word or compensation value that changes while run is high takes effect at the first clock of the next period. Values present while run is low are used by the period that starts when run rises.
- R8: After reset with run low, the outputs are parked as in R6. The first run after reset follows R1 to R5 for the configuration presented while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables the timebase; low parks SCL high |
| ctl_word | input | PW+6 | Control word: period step field above the prescale field |
| comp_cfg | input | 5 | Rise/fall/delay compensation in ticks |
| scl_low_req | output | 1 | Request to drive SCL low |
| scl_high_req | output | 1 | Request to release SCL high |
| qtr_stb | output | 1 | Quarter-period boundary strobe |
| qtr_idx | output | 2 | Which quarter boundary the strobe marks |

## Verification
The bench builds two copies of the block side by side, one with WIDE_PSC=0 and one with WIDE_PSC=1, and compares both against a closed-form model in every clock. The narrow copy covers prescale values 0 to 3. The wide copy also reaches prescale values 4 to 7 and the shifted position of the period field. Because the 5-bit compensation and the 6-bit step field are small, the bench can sweep every step value and every compensation value through a full period. This brings in both odd and even period lengths, the shortest period of 20 ticks, and the longest of 555 ticks. It also covers mid-period configuration changes and re-enables after parking.

// File: rtl/scl_timebase.sv
`timescale 1ns/1ps
module scl_timebase #(
  parameter bit WIDE_PSC   = 1'b0,
  parameter int SCGD_W     = 6,
  parameter int COMP_W     = 5,
  parameter int BASE_TICKS = 20,
  parameter int STEP_SHIFT = 3,
  localparam int PSC_W = WIDE_PSC ? 3 : 2,
  localparam int CTL_W = SCGD_W + PSC_W,
  localparam int PER_W = SCGD_W + STEP_SHIFT + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic [COMP_W-1:0] comp_cfg,
  output logic              scl_low_req,
  output logic              scl_high_req,
  output logic              qtr_stb,
  output logic [1:0]        qtr_idx
);

  logic [PSC_W-1:0]  cdf_q, psc_q;
  logic [SCGD_W-1:0] step_q;
  logic [COMP_W-1:0] comp_q;
  logic [PER_W-1:0]  pos_q, per, hi_len, lo_len, mark1, mark3;
  logic              fresh_q, tick, wrap, hit;

  assign per    = PER_W'(BASE_TICKS) + (PER_W'(step_q) << STEP_SHIFT) + PER_W'(comp_q);
  assign hi_len = per >> 1;
  assign lo_len = per - hi_len;
  assign mark1  = lo_len >> 1;
  assign mark3  = lo_len + (hi_len >> 1);

  assign tick = run && (psc_q == cdf_q);
  assign wrap = tick && (pos_q == per - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cdf_q   <= '0;
      step_q  <= '0;
      comp_q  <= '0;
      psc_q   <= '0;
      pos_q   <= '0;
      fresh_q <= 1'b1;
    end else if (!run) begin
      psc_q   <= '0;
      pos_q   <= '0;
      fresh_q <= 1'b1;
      cdf_q   <= ctl_word[PSC_W-1:0];
      step_q  <= ctl_word[CTL_W-1:PSC_W];
      comp_q  <= comp_cfg;
    end else begin
      fresh_q <= tick;
      psc_q   <= tick ? '0 : psc_q + PSC_W'(1);
      if (tick) pos_q <= wrap ? '0 : pos_q + PER_W'(1);
      if (wrap) begin
        cdf_q  <= ctl_word[PSC_W-1:0];
        step_q <= ctl_word[CTL_W-1:PSC_W];
        comp_q <= comp_cfg;
      end
    end
  end

  always_comb begin
    hit     = 1'b1;
    qtr_idx = 2'd0;
    if (pos_q == '0)         qtr_idx = 2'd0;
    else if (pos_q == mark1)  qtr_idx = 2'd1;
    else if (pos_q == lo_len) qtr_idx = 2'd2;
    else if (pos_q == mark3)  qtr_idx = 2'd3;
    else                      hit = 1'b0;
  end

  assign qtr_stb      = run && fresh_q && hit;
  assign scl_low_req  = run && (pos_q < lo_len);
  assign scl_high_req = !scl_low_req;

  a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (pos_q == $past(pos_q)));

  a_r3_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos_q < per));

  a_r4_low_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (qtr_stb && qtr_idx == 2'd0) |-> scl_low_req);

  a_r4_high_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    (qtr_stb && qtr_idx == 2'd2) |-> scl_high_req);

  a_r6_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (scl_high_req && !scl_low_req && !qtr_stb));

  a_r7_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> (step_q == $past(step_q) && cdf_q == $past(cdf_q) && comp_q == $past(comp_q)));

endmodule

// File: tb/test_scl_timebase.sv
`timescale 1ns/1ps
module test_scl_timebase;
  logic       clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [7:0] ctl_n;
  logic [8:0] ctl_w;
  logic [4:0] comp;
  logic       lo_n, hi_n, stb_n, lo_w, hi_w, stb_w;
  logic [1:0] idx_n, idx_w;
  int         checks = 0, errors = 0;

  always #4 clk = ~clk;

  scl_timebase #(.WIDE_PSC(1'b0)) i_scl_timebase (
    .clk(clk), .rst_n(rst_n), .run(run), .ctl_word(ctl_n), .comp_cfg(comp),
    .scl_low_req(lo_n), .scl_high_req(hi_n), .qtr_stb(stb_n), .qtr_idx(idx_n));

  scl_timebase #(.WIDE_PSC(1'b1)) i_scl_timebase_wide (
    .clk(clk), .rst_n(rst_n), .run(run), .ctl_word(ctl_w), .comp_cfg(comp),
    .scl_low_req(lo_w), .scl_high_req(hi_w), .qtr_stb(stb_w), .qtr_idx(idx_w));

  function automatic logic [4:0] model(int cdf, int step, int cmp, int k);
    int p, h, l, c;
    logic s;
    logic [1:0] ix;
    p = 20 + 8 * step + cmp;
    h = p / 2;
    l = p - h;
    c = (k / (cdf + 1)) % p;
    s = 1'b0;
    ix = 2'd0;
    if (k % (cdf + 1) == 0) begin
      if (c == 0)                begin s = 1'b1; ix = 2'd0; end
      else if (c == l / 2)       begin s = 1'b1; ix = 2'd1; end
      else if (c == l)           begin s = 1'b1; ix = 2'd2; end
      else if (c == l + h / 2)   begin s = 1'b1; ix = 2'd3; end
    end
    return {s, ix, (c < l), !(c < l)};
  endfunction

  function automatic int span(int cdf, int step, int cmp);
    return (20 + 8 * step + cmp) * (cdf + 1);
  endfunction

  task automatic check(string req, string tag, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b (stb idx lo hi)", req, tag, got, exp);
    end
  endtask

  task automatic sample(string req, bit wide_only, logic [4:0] exp);
    check(req, "wide", {stb_w, stb_w ? idx_w : 2'b00, lo_w, hi_w}, exp);
    if (!wide_only)
      check(req, "narrow", {stb_n, stb_n ? idx_n : 2'b00, lo_n, hi_n}, exp);
  endtask

  task automatic load(int cdf, int step, int cmp);
    ctl_n = {6'(step), 2'(cdf)};
    ctl_w = {6'(step), 3'(cdf)};
    comp  = 5'(cmp);
  endtask

  task automatic run_case(string req, int cdf, int step, int cmp, int ncyc);
    @(negedge clk);
    run = 1'b0;
    load(cdf, step, cmp);
    #1 sample("R6", 1'b0, 5'b00001);
    @(negedge clk);
    #1 sample("R6", 1'b0, 5'b00001);
    @(negedge clk);
    run = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      #1 sample(req, cdf > 3, model(cdf, step, cmp, k));
      @(negedge clk);
    end
  endtask

  task automatic run_switch(int ca, int sa, int pa, int cb, int sb, int pb, int at);
    int ta, n;
    ta = span(ca, sa, pa);
    n  = ta + span(cb, sb, pb) + 4;
    @(negedge clk);
    run = 1'b0;
    load(ca, sa, pa);
    @(negedge clk);
    run = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (k == at) load(cb, sb, pb);
      #1 sample("R7", (ca > 3) || (cb > 3),
                k < ta ? model(ca, sa, pa, k) : model(cb, sb, pb, k - ta));
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    load(1, 2, 3);
    repeat (3) @(negedge clk);
    #1 sample("R8", 1'b0, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    #1 sample("R8", 1'b0, 5'b00001);
    @(negedge clk);
    run = 1'b1;
    for (int k = 0; k < span(1, 2, 3) + 6; k++) begin
      #1 sample("R8", 1'b0, model(1, 2, 3, k));
      @(negedge clk);
    end

    // R1: prescale sweep on both variants
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 3; s += 2)
        for (int p = 0; p < 8; p += 7)
          run_case("R1", c, s, p, span(c, s, p) + 2 * (c + 1) + 3);

    // R2: prescale values that only the wide field holds, extreme step field
    for (int c = 4; c < 8; c++) begin
      run_case("R2", c, 63, 31, span(c, 63, 31) + c + 3);
      run_case("R2", c, 0, 0, span(c, 0, 0) + c + 3);
    end

    // R3: every period step value
    for (int s = 0; s < 64; s++)
      run_case("R3", 0, s, 0, span(0, s, 0) + 2);

    // R4: every compensation value, odd and even periods
    for (int p = 0; p < 32; p++)
      run_case("R4", 0, 1, p, span(0, 1, p) + 2);

    // R5: quarter strobes at slow prescale, odd period halves
    run_case("R5", 3, 5, 3, 2 * span(3, 5, 3));
    run_case("R5", 2, 0, 1, 2 * span(2, 0, 1));

    // R6: re-enable right after a short run restarts at position 0
    run_case("R6", 0, 2, 5, 17);
    run_case("R6", 1, 2, 5, span(1, 2, 5) + 4);

    // R7: mid-period control changes apply at the next period
    run_switch(0, 3, 4, 2, 1, 9, 3);
    run_switch(3, 0, 0, 0, 7, 1, span(3, 0, 0) - 1);
    run_switch(1, 4, 0, 6, 2, 2, 10);

    summary();
  end
endmodule